// File: doc/BRIEF.md
# Paired Register File with 16-bit Pair Unit

This block is the register file of a small 8-bit processor core. It holds an accumulator, six general 8-bit registers, a 16-bit stack pointer and an 8-bit flag byte. The decoder and the 8-bit ALU outside it read and write single registers by a 3-bit index. They read any 16-bit pair by a 2-bit selector, and they read or write the accumulator and flag byte together as one 16-bit status word.

The 16-bit pair arithmetic is built into the file, so it needs no trip through the 8-bit ALU. One command per cycle can do any of these:
- load a pair from a 16-bit immediate;
- increment or decrement a pair;
- add a pair into HL, where only the carry flag changes;
- swap HL with DE.

A further command swaps HL with the 16-bit word on top of the stack. It runs four byte transfers over a request/acknowledge memory port and raises `busy` until the last transfer is acknowledged.

Top module: `pairreg_file`

## Requirements
- R1: After reset every 8-bit register, the stack pointer and the flag byte read as zero, `busy` is 0 and `mem_req` is 0.
- R2: Register index encoding is B=0, C=1, D=2, E=3, H=4, L=5, A=7. `wr8_en` writes `wr8_data` into the indexed register at the clock edge, and `rd8_data` shows the indexed register. Index 6 is the memory-through-HL slot: a write to it changes no register, and reading it returns 8'h00.
- R3: The pair selector encoding is 0=BC, 1=DE, 2=HL, 3=SP, and the first-named register is the high byte. `rd16_data` shows the selected pair. Command code 1 loads `op_imm` into the pair named by `op_pair`.
- R4: Command 2 increments the selected pair and command 3 decrements it, both modulo 65536. Neither changes any flag bit.
- R5: Command 4 adds the selected pair into HL modulo 65536. Flag bit 0 (carry) takes the carry out of bit 15, and flag bits 7..1 keep their values.
- R6: Command 4 with the HL selector shifts HL left by one bit, and the old bit 15 goes to carry.
- R7: Command 5 swaps the whole of HL with the whole of DE in one cycle, whatever `op_pair` holds.
- R8: Command 6 runs the stack-top swap in a fixed order: read the byte at SP, read the byte at SP+1 (modulo 65536), write the old L to SP, then write the old H to SP+1. Each request holds its address, direction and data until `mem_ack`. `busy` is 1 from the cycle after the command is taken until the cycle after the last acknowledge. In that cycle HL holds {byte read from SP+1, byte read from SP}, and SP is unchanged.
- R9: While `busy` is 1, commands, 8-bit writes and status-word writes are ignored. A command taken in a cycle blocks the 8-bit write and the status-word write of that same cycle. Command codes 0 and 7 do nothing.
- R10: `psw_rd` is {A, flags}. `psw_wr_en` loads A from bits 15..8 and the flag byte from bits 7..0, and it wins over an 8-bit write to A in the same cycle. `carry` is flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr8_en | input | 1 | 8-bit register write enable |
| wr8_idx | input | 3 | 8-bit write index |
| wr8_data | input | 8 | 8-bit write data |
| rd8_idx | input | 3 | 8-bit read index |
| rd8_data | output | 8 | Selected 8-bit register |
| rd16_pair | input | 2 | 16-bit read selector |
| rd16_data | output | 16 | Selected pair or SP |
| psw_wr_en | input | 1 | Status word write enable |
| psw_wr_data | input | 16 | Status word write data, {A, flags} |
| psw_rd | output | 16 | Status word, {A, flags} |
| carry | output | 1 | Carry flag |
| op_valid | input | 1 | Pair command valid |
| op_code | input | 3 | Command code: 0 none, 1 load, 2 inc, 3 dec, 4 add to HL, 5 swap DE/HL, 6 stack-top swap, 7 none |
| op_pair | input | 2 | Pair selector for the command |
| op_imm | input | 16 | Immediate for the load |
| busy | output | 1 | Stack-top swap in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge, one per request |

## Verification
The hardest case to reach is a command or register write that arrives while the stack-top swap is still waiting on memory. The ports can only show it being ignored if the memory holds the swap open long enough for the write to land. The bench's directed swap task acts as the memory itself. It holds each acknowledge back for a chosen number of cycles and fires a load and an accumulator write in the first busy cycle. After the swap it reads BC and A back to show they did not move. A second swap with SP at 16'hFFFF makes the high-byte address wrap to 16'h0000.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_ADDHL = 3'd4,
        OP_XDEHL = 3'd5,
        OP_XSTK  = 3'd6,
        OP_RSVD  = 3'd7
    } pair_op_e;

    typedef enum logic [1:0] {
        AM_INC = 2'd0,
        AM_DEC = 2'd1,
        AM_ADD = 2'd2
    } add_mode_e;

    typedef enum logic [2:0] {
        SW_IDLE  = 3'd0,
        SW_RD_LO = 3'd1,
        SW_RD_HI = 3'd2,
        SW_WR_LO = 3'd3,
        SW_WR_HI = 3'd4
    } swap_state_e;

    localparam logic [2:0] IDX_B   = 3'd0;
    localparam logic [2:0] IDX_C   = 3'd1;
    localparam logic [2:0] IDX_D   = 3'd2;
    localparam logic [2:0] IDX_E   = 3'd3;
    localparam logic [2:0] IDX_H   = 3'd4;
    localparam logic [2:0] IDX_L   = 3'd5;
    localparam logic [2:0] IDX_MEM = 3'd6;
    localparam logic [2:0] IDX_A   = 3'd7;

    localparam logic [1:0] PR_BC = 2'd0;
    localparam logic [1:0] PR_DE = 2'd1;
    localparam logic [1:0] PR_HL = 2'd2;
    localparam logic [1:0] PR_SP = 2'd3;

endpackage

// File: rtl/pairreg_adder16.sv
module pairreg_adder16
    import pairreg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  add_mode_e    mode,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        case (mode)
            AM_INC:  wide = {1'b0, a} + {{W{1'b0}}, 1'b1};
            AM_DEC:  wide = {1'b0, a - {{(W-1){1'b0}}, 1'b1}};
            AM_ADD:  wide = {1'b0, a} + {1'b0, b};
            default: wide = {1'b0, a};
        endcase
        sum  = wide[W-1:0];
        cout = (mode == AM_ADD) ? wide[W] : 1'b0;
    end

endmodule

// File: rtl/pairreg_stack_swap.sv
module pairreg_stack_swap
    import pairreg_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] sp,
    input  logic [2*DW-1:0] hl,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic [2*DW-1:0] swap_word
);
    typedef struct packed {
        swap_state_e   st;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } sw_t;

    sw_t sw_d, sw_q;
    logic [AW-1:0] sp_next;

    assign sp_next = sp + {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        sw_d      = sw_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        done      = 1'b0;
        case (sw_q.st)
            SW_IDLE: begin
                if (start) sw_d.st = SW_RD_LO;
            end
            SW_RD_LO: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    sw_d.lo = mem_rdata;
                    sw_d.st = SW_RD_HI;
                end
            end
            SW_RD_HI: begin
                mem_req  = 1'b1;
                mem_addr = sp_next;
                if (mem_ack) begin
                    sw_d.hi = mem_rdata;
                    sw_d.st = SW_WR_LO;
                end
            end
            SW_WR_LO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hl[DW-1:0];
                if (mem_ack) sw_d.st = SW_WR_HI;
            end
            SW_WR_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_next;
                mem_wdata = hl[2*DW-1:DW];
                if (mem_ack) begin
                    done    = 1'b1;
                    sw_d.st = SW_IDLE;
                end
            end
            default: sw_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '{st: SW_IDLE, lo: '0, hi: '0};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign busy      = (sw_q.st != SW_IDLE);
    assign swap_word = {sw_q.hi, sw_q.lo};

    // R8: a pending request keeps its address, direction and data until acknowledged
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R8: the swap completes only through a final write acknowledge
    assert_done_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_req && mem_we && mem_ack));

endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
    import pairreg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr8_en,
    input  logic [2:0]      wr8_idx,
    input  logic [DW-1:0]   wr8_data,
    input  logic [2:0]      rd8_idx,
    output logic [DW-1:0]   rd8_data,
    input  logic [1:0]      rd16_pair,
    output logic [2*DW-1:0] rd16_data,
    input  logic            psw_wr_en,
    input  logic [2*DW-1:0] psw_wr_data,
    output logic [2*DW-1:0] psw_rd,
    output logic            carry,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [1:0]      op_pair,
    input  logic [2*DW-1:0] op_imm,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack
);
    localparam int PW   = 2 * DW;
    localparam int NREG = 8;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
        logic [PW-1:0]           sp;
        logic [DW-1:0]           flags;
    } rf_t;

    rf_t rf_d, rf_q;

    logic            accept;
    pair_op_e        op;
    logic [PW-1:0]   bc_q, de_q, hl_q, sel_val;
    logic [PW-1:0]   ar_sum;
    logic            ar_cout;
    add_mode_e       ar_mode;
    logic            sw_busy, sw_done, sw_start;
    logic [PW-1:0]   sw_word;
    logic            w16_en;
    logic [1:0]      w16_pair;
    logic [PW-1:0]   w16_val;

    assign op     = pair_op_e'(op_code);
    assign accept = op_valid && !sw_busy;
    assign bc_q   = {rf_q.r[IDX_B], rf_q.r[IDX_C]};
    assign de_q   = {rf_q.r[IDX_D], rf_q.r[IDX_E]};
    assign hl_q   = {rf_q.r[IDX_H], rf_q.r[IDX_L]};

    function automatic logic [PW-1:0] pick_pair(input logic [1:0] p, input rf_t s);
        case (p)
            PR_BC:   pick_pair = {s.r[IDX_B], s.r[IDX_C]};
            PR_DE:   pick_pair = {s.r[IDX_D], s.r[IDX_E]};
            PR_HL:   pick_pair = {s.r[IDX_H], s.r[IDX_L]};
            default: pick_pair = s.sp;
        endcase
    endfunction

    assign sel_val = pick_pair(op_pair, rf_q);

    always_comb begin
        case (op)
            OP_DEC:   ar_mode = AM_DEC;
            OP_ADDHL: ar_mode = AM_ADD;
            default:  ar_mode = AM_INC;
        endcase
    end

    pairreg_adder16 #(.W(PW)) u_adder (
        .a    (sel_val),
        .b    (hl_q),
        .mode (ar_mode),
        .sum  (ar_sum),
        .cout (ar_cout)
    );

    assign sw_start = accept && (op == OP_XSTK);

    pairreg_stack_swap #(.DW(DW), .AW(PW)) u_swap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sw_start),
        .sp        (rf_q.sp),
        .hl        (hl_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .busy      (sw_busy),
        .done      (sw_done),
        .swap_word (sw_word)
    );

    always_comb begin
        rf_d     = rf_q;
        w16_en   = 1'b0;
        w16_pair = op_pair;
        w16_val  = op_imm;

        if (accept) begin
            case (op)
                OP_LOAD: w16_en = 1'b1;
                OP_INC, OP_DEC: begin
                    w16_en  = 1'b1;
                    w16_val = ar_sum;
                end
                OP_ADDHL: begin
                    w16_en      = 1'b1;
                    w16_pair    = PR_HL;
                    w16_val     = ar_sum;
                    rf_d.flags[0] = ar_cout;
                end
                OP_XDEHL: begin
                    rf_d.r[IDX_D] = rf_q.r[IDX_H];
                    rf_d.r[IDX_E] = rf_q.r[IDX_L];
                    rf_d.r[IDX_H] = rf_q.r[IDX_D];
                    rf_d.r[IDX_L] = rf_q.r[IDX_E];
                end
                default: ;
            endcase
        end else if (!sw_busy) begin
            if (wr8_en && (wr8_idx != IDX_MEM)) rf_d.r[wr8_idx] = wr8_data;
            if (psw_wr_en) begin
                rf_d.r[IDX_A] = psw_wr_data[PW-1:DW];
                rf_d.flags    = psw_wr_data[DW-1:0];
            end
        end

        if (w16_en) begin
            case (w16_pair)
                PR_BC:   {rf_d.r[IDX_B], rf_d.r[IDX_C]} = w16_val;
                PR_DE:   {rf_d.r[IDX_D], rf_d.r[IDX_E]} = w16_val;
                PR_HL:   {rf_d.r[IDX_H], rf_d.r[IDX_L]} = w16_val;
                default: rf_d.sp = w16_val;
            endcase
        end

        if (sw_done) {rf_d.r[IDX_H], rf_d.r[IDX_L]} = sw_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd8_data  = (rd8_idx == IDX_MEM) ? '0 : rf_q.r[rd8_idx];
    assign rd16_data = pick_pair(rd16_pair, rf_q);
    assign psw_rd    = {rf_q.r[IDX_A], rf_q.flags};
    assign carry     = rf_q.flags[0];
    assign busy      = sw_busy;

    // R4: pair increment and decrement leave the whole flag byte alone
    assert_incdec_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_INC || op == OP_DEC)) |=> $stable(rf_q.flags));

    // R5: the pair add may touch carry only
    assert_add_upper_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ADDHL) |=> (rf_q.flags[DW-1:1] == $past(rf_q.flags[DW-1:1])));

    // R7: the DE/HL swap exchanges both pairs in one step
    assert_xchg_de_hl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_XDEHL) |=> (hl_q == $past(de_q) && de_q == $past(hl_q)));

    // R9: during a stack-top swap nothing moves the stack pointer or the general pairs
    assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy |=> ($stable(rf_q.sp) && $stable(bc_q) && $stable(rf_q.r[IDX_A])));

    // R8: memory requests only exist while the swap is running
    assert_req_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: tb/pairreg_file_tb.sv
module pairreg_file_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr8_en = 1'b0;
    logic [2:0]  wr8_idx = '0;
    logic [7:0]  wr8_data = '0;
    logic [2:0]  rd8_idx = '0;
    logic [7:0]  rd8_data;
    logic [1:0]  rd16_pair = '0;
    logic [15:0] rd16_data;
    logic        psw_wr_en = 1'b0;
    logic [15:0] psw_wr_data = '0;
    logic [15:0] psw_rd;
    logic        carry;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_pair = '0;
    logic [15:0] op_imm = '0;
    logic        busy;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pairreg_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr8_en(wr8_en), .wr8_idx(wr8_idx), .wr8_data(wr8_data),
        .rd8_idx(rd8_idx), .rd8_data(rd8_data),
        .rd16_pair(rd16_pair), .rd16_data(rd16_data),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data), .psw_rd(psw_rd),
        .carry(carry),
        .op_valid(op_valid), .op_code(op_code), .op_pair(op_pair), .op_imm(op_imm),
        .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd8(input logic [2:0] idx, output logic [7:0] v);
        rd8_idx = idx;
        #1 v = rd8_data;
    endtask

    task automatic rd16(input logic [1:0] p, output logic [15:0] v);
        rd16_pair = p;
        #1 v = rd16_data;
    endtask

    task automatic write8(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr8_en = 1'b1; wr8_idx = idx; wr8_data = d;
        @(negedge clk);
        wr8_en = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] code, input logic [1:0] p, input logic [15:0] imm);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_pair = p; op_imm = imm;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic write_psw(input logic [15:0] d);
        @(negedge clk);
        psw_wr_en = 1'b1; psw_wr_data = d;
        @(negedge clk);
        psw_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v8;
        logic [15:0] v16;
        for (int i = 0; i < 8; i++) begin
            rd8(3'(i), v8);
            chk("R1 reg", {8'h00, v8}, 16'h0000);
        end
        rd16(2'd3, v16);
        chk("R1 sp", v16, 16'h0000);
        chk("R1 psw", psw_rd, 16'h0000);
        chk("R1 busy/req", {14'h0, busy, mem_req}, 16'h0000);
    endtask

    task automatic t_byte_access;
        logic [7:0] v8;
        logic [15:0] v16;
        for (int i = 0; i < 8; i++) write8(3'(i), 8'h11 * 8'(i + 1));
        for (int i = 0; i < 8; i++) begin
            rd8(3'(i), v8);
            chk("R2 byte", {8'h00, v8}, (i == 6) ? 16'h0000 : {8'h00, 8'h11 * 8'(i + 1)});
        end
        rd16(2'd0, v16); chk("R3 BC order", v16, 16'h1122);
        rd16(2'd1, v16); chk("R3 DE order", v16, 16'h3344);
        rd16(2'd2, v16); chk("R3 HL order", v16, 16'h5566);
        chk("R10 psw A", psw_rd, 16'h8800);
    endtask

    task automatic t_load_incdec;
        logic [15:0] v16;
        cmd(3'd1, 2'd0, 16'hBEEF); rd16(2'd0, v16); chk("R3 load BC", v16, 16'hBEEF);
        cmd(3'd1, 2'd3, 16'hFFFF); rd16(2'd3, v16); chk("R3 load SP", v16, 16'hFFFF);
        write_psw(16'h42D5);
        cmd(3'd2, 2'd3, 16'h0);    rd16(2'd3, v16); chk("R4 inc wrap", v16, 16'h0000);
        chk("R4 flags after inc", psw_rd, 16'h42D5);
        cmd(3'd3, 2'd3, 16'h0);    rd16(2'd3, v16); chk("R4 dec wrap", v16, 16'hFFFF);
        cmd(3'd2, 2'd1, 16'h0);    rd16(2'd1, v16); chk("R4 inc DE", v16, 16'h3345);
        cmd(3'd3, 2'd0, 16'h0);    rd16(2'd0, v16); chk("R4 dec BC", v16, 16'hBEEE);
        chk("R4 flags after dec", psw_rd, 16'h42D5);
    endtask

    task automatic t_add;
        logic [15:0] v16;
        write_psw(16'h00FE);
        cmd(3'd1, 2'd2, 16'h8000);
        cmd(3'd1, 2'd0, 16'h8001);
        cmd(3'd4, 2'd0, 16'h0);
        rd16(2'd2, v16); chk("R5 add sum", v16, 16'h0001);
        chk("R5 carry set, upper kept", psw_rd, 16'h00FF);
        cmd(3'd1, 2'd3, 16'h0010);
        cmd(3'd4, 2'd3, 16'h0);
        rd16(2'd2, v16); chk("R5 add SP", v16, 16'h0011);
        chk("R5 carry clear", {15'h0, carry}, 16'h0000);
        chk("R5 upper flags", psw_rd, 16'h00FE);
        cmd(3'd1, 2'd2, 16'hC001);
        cmd(3'd4, 2'd2, 16'h0);
        rd16(2'd2, v16); chk("R6 HL shift", v16, 16'h8002);
        chk("R6 carry from bit15", {15'h0, carry}, 16'h0001);
    endtask

    task automatic t_xchg_de;
        logic [15:0] v16;
        cmd(3'd1, 2'd1, 16'h1357);
        cmd(3'd1, 2'd2, 16'h2468);
        cmd(3'd5, 2'd3, 16'hFFFF);
        rd16(2'd1, v16); chk("R7 DE gets HL", v16, 16'h2468);
        rd16(2'd2, v16); chk("R7 HL gets DE", v16, 16'h1357);
        rd16(2'd3, v16); chk("R7 SP untouched", v16, 16'h0010);
    endtask

    task automatic t_priority;
        logic [7:0] v8;
        logic [15:0] v16;
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; op_pair = 2'd2; op_imm = 16'hA0A1;
        wr8_en = 1'b1; wr8_idx = 3'd7; wr8_data = 8'h5C;
        @(negedge clk);
        op_valid = 1'b0; wr8_en = 1'b0;
        rd8(3'd7, v8); chk("R9 write blocked by command", {8'h0, v8}, 16'h0000);
        rd16(2'd2, v16); chk("R9 command wins", v16, 16'hA0A1);
        cmd(3'd7, 2'd2, 16'h1111);
        cmd(3'd0, 2'd2, 16'h2222);
        rd16(2'd2, v16); chk("R9 codes 0/7 no effect", v16, 16'hA0A1);
        @(negedge clk);
        wr8_en = 1'b1; wr8_idx = 3'd7; wr8_data = 8'h33;
        psw_wr_en = 1'b1; psw_wr_data = 16'h9A01;
        @(negedge clk);
        wr8_en = 1'b0; psw_wr_en = 1'b0;
        chk("R10 psw wins over A write", psw_rd, 16'h9A01);
        chk("R10 carry is flag bit0", {15'h0, carry}, 16'h0001);
    endtask

    task automatic t_stack_swap(input logic [15:0] sp, input logic [15:0] hl,
                                input logic [7:0] lo, input logic [7:0] hi, input int lat);
        logic [15:0] bc0, v16, exp_addr;
        logic [15:0] a0;
        logic [7:0]  exp_wd;
        logic        exp_we;
        int guard;
        cmd(3'd1, 2'd3, sp);
        cmd(3'd1, 2'd2, hl);
        rd16(2'd0, bc0);
        a0 = psw_rd;
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd6; op_pair = 2'd0;
        @(negedge clk);
        chk("R8 busy after start", {15'h0, busy}, 16'h0001);
        op_valid = 1'b1; op_code = 3'd1; op_pair = 2'd0; op_imm = 16'hFFFF;
        wr8_en = 1'b1; wr8_idx = 3'd7; wr8_data = 8'h77;
        psw_wr_en = 1'b1; psw_wr_data = 16'h0000;
        @(negedge clk);
        op_valid = 1'b0; wr8_en = 1'b0; psw_wr_en = 1'b0;
        for (int step = 0; step < 4; step++) begin
            guard = 0;
            while (!mem_req && guard < 20) begin
                @(negedge clk);
                guard++;
            end
            exp_addr = (step % 2 == 0) ? sp : sp + 16'd1;
            exp_we   = (step >= 2);
            exp_wd   = (step == 2) ? hl[7:0] : hl[15:8];
            chk("R8 addr", mem_addr, exp_addr);
            chk("R8 dir", {15'h0, mem_we}, {15'h0, exp_we});
            if (exp_we) chk("R8 wdata", {8'h0, mem_wdata}, {8'h0, exp_wd});
            for (int w = 0; w < lat; w++) @(negedge clk);
            chk("R8 held", {mem_req, mem_we, mem_addr[13:0]}, {1'b1, exp_we, exp_addr[13:0]});
            mem_ack = 1'b1;
            mem_rdata = (step == 0) ? lo : hi;
            @(negedge clk);
            mem_ack = 1'b0;
            mem_rdata = 8'h00;
            if (step < 3) chk("R8 busy mid", {15'h0, busy}, 16'h0001);
        end
        chk("R8 busy clear", {15'h0, busy}, 16'h0000);
        rd16(2'd2, v16); chk("R8 HL from stack", v16, {hi, lo});
        rd16(2'd3, v16); chk("R8 SP kept", v16, sp);
        rd16(2'd0, v16); chk("R9 BC ignored while busy", v16, bc0);
        chk("R9 psw ignored while busy", psw_rd, a0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_access();
        t_load_incdec();
        t_add();
        t_xchg_de();
        t_priority();
        t_stack_swap(16'h1234, 16'hABCD, 8'h5A, 8'hC3, 2);
        t_stack_swap(16'hFFFF, 16'h0F1E, 8'h96, 8'h69, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule